// File: doc/BRIEF.md
# Bridge PWM Generator with Fault Shutdown

This block produces one pulse-width-modulated waveform and routes it onto four pins. The pins can be set up as a complementary half-bridge pair or as a full bridge that drives current in either of two directions. The period is built from a period register plus a two-bit prescaler count, which gives a 10-bit time base. A 10-bit duty value is compared against that time base. Period, duty, bridge mode and direction are all held in shadow registers and take effect only at the next period boundary.

A high level on the fault input forces all four pins into a preselected safe state in the same cycle. It also sets a shutdown flag. In auto-restart mode the flag drops as soon as the fault goes away. Otherwise the flag stays set until software clears it. In both modes the pins return to normal modulation only at the start of a new period. This means neither a restart nor a direction change can produce a truncated pulse. A one-cycle end-of-period pulse marks the last count of every period.

Top module: `pwm_bridge_guard`

## Requirements
- R1: With active period register P, a period lasts 4*(P+1) clock cycles. `period_end` is high only in the last cycle of each period, including P=0.
- R2: Pin A, bit 0 of `pwm_out`, is high in cycle k of a period (k=0 at the start) exactly when k < D, where D is the active duty value. The high count is therefore min(D, 4*(P+1)). D = 4*(P+1)-1 gives exactly one low cycle.
- R3: Values on `period_in`, `duty_in`, `full_bridge` and `reverse` are captured only in the last cycle of a period. A change made in the middle of a period does not alter that period.
- R4: In half-bridge mode (`full_bridge`=0), pin B (bit 1) is the inverse of pin A, and pins C (bit 2) and D (bit 3) are low.
- R5: In full-bridge mode with `reverse`=0, A is high, D carries the modulation, and B and C are low. With `reverse`=1, C is high, B carries the modulation, and A and D are low.
- R6: A direction change made in the middle of a period leaves the old direction on the pins until that period ends.
- R7: While `fault_in` is high, the pins take their shutdown state in the same cycle. `sd_flag` is set from the next cycle onward.
- R8: Pins A and C follow `ssel_ac`, and pins B and D follow `ssel_bd`. Code 00 drives low, code 01 drives high, and codes 10 and 11 release the pin (enable 0, value 0). Outside shutdown, all enables are 1.
- R9: With `auto_restart`=1, `sd_flag` clears in the cycle after `fault_in` goes low. The pins stay forced until the next period begins, then modulate normally from cycle 0.
- R10: With `auto_restart`=0, `sd_flag` stays set after the fault ends until a one-cycle `sd_clear` pulse arrives while `fault_in` is low. A `sd_clear` pulse while the fault is high has no effect.
- R11: During reset, the outputs are `sd_flag`=0, `period_end`=0, `pwm_out`=4'b0010 and `pwm_oe`=4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| period_in | input | PER_W | Period register, shadowed |
| duty_in | input | PER_W+2 | Duty value, shadowed |
| full_bridge | input | 1 | 1 selects full-bridge routing |
| reverse | input | 1 | Full-bridge direction, shadowed |
| fault_in | input | 1 | High level requests shutdown |
| auto_restart | input | 1 | 1 lets the flag clear when the fault ends |
| sd_clear | input | 1 | Software clear of the shutdown flag |
| ssel_ac | input | 2 | Shutdown state for pins A and C |
| ssel_bd | input | 2 | Shutdown state for pins B and D |
| pwm_out | output | 4 | Pin values, bit 0 = A up to bit 3 = D |
| pwm_oe | output | 4 | Pin output enables |
| sd_flag | output | 1 | Shutdown active |
| period_end | output | 1 | Last cycle of a period |

## Verification
Fault release and the period boundary can fall in the same cycle. In that case the flag clears and the restart gate opens on the same clock edge. The bench drops the fault in exactly the cycle where `period_end` is seen. It then requires that the following period be a complete, unshortened pulse starting at cycle 0. Direction and duty writes are also placed in the middle of a period. The bench checks cycle by cycle that the pins do not switch until the boundary.

// File: rtl/pwm_bridge_guard.sv
module pwm_bridge_guard #(
  parameter int PER_W = 8,
  parameter int PRE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PER_W-1:0]       period_in,
  input  logic [PER_W+PRE_W-1:0] duty_in,
  input  logic                   full_bridge,
  input  logic                   reverse,
  input  logic                   fault_in,
  input  logic                   auto_restart,
  input  logic                   sd_clear,
  input  logic [1:0]             ssel_ac,
  input  logic [1:0]             ssel_bd,
  output logic [3:0]             pwm_out,
  output logic [3:0]             pwm_oe,
  output logic                   sd_flag,
  output logic                   period_end
);
  localparam int CNT_W = PER_W + PRE_W;

  logic [CNT_W-1:0] cnt, duty_q;
  logic [PER_W-1:0] per_q;
  logic             fb_q, rev_q, run, sd_q;

  wire [CNT_W-1:0] last  = {per_q, {PRE_W{1'b1}}};
  wire             wrap  = (cnt == last);
  wire             sd_nx = fault_in | (sd_q & ~auto_restart & ~sd_clear);
  wire             mod   = (cnt < duty_q);
  wire             shut  = fault_in | ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_q <= '0;
      per_q  <= '0;
      fb_q   <= 1'b0;
      rev_q  <= 1'b0;
      sd_q   <= 1'b0;
      run    <= 1'b1;
    end else begin
      cnt  <= wrap ? '0 : cnt + 1'b1;
      sd_q <= sd_nx;
      if (wrap) begin
        per_q  <= period_in;
        duty_q <= duty_in;
        fb_q   <= full_bridge;
        rev_q  <= reverse;
      end
      if (sd_nx)     run <= 1'b0;
      else if (wrap) run <= 1'b1;
    end
  end

  logic [3:0] live;
  always_comb begin
    if (!fb_q)      live = {2'b00, ~mod, mod};
    else if (rev_q) live = {1'b0, 1'b1, mod, 1'b0};
    else            live = {mod, 1'b0, 1'b0, 1'b1};
  end

  for (genvar i = 0; i < 4; i++) begin : g_pin
    wire [1:0] sel = (i % 2 == 0) ? ssel_ac : ssel_bd;
    assign pwm_out[i] = shut ? (sel == 2'b01) : live[i];
    assign pwm_oe[i]  = shut ? ~sel[1] : 1'b1;
  end

  assign sd_flag    = sd_q;
  assign period_end = wrap;
endmodule

module pwm_bridge_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_in,
  input logic       auto_restart,
  input logic       sd_clear,
  input logic [1:0] ssel_ac,
  input logic [3:0] pwm_out,
  input logic [3:0] pwm_oe,
  input logic       sd_flag,
  input logic       period_end,
  input logic       run
);
  a_r7_fault_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && ssel_ac == 2'b00) |-> (pwm_out[0] == 1'b0 && pwm_out[2] == 1'b0));
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> sd_flag);
  a_r10_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_flag && !auto_restart && !sd_clear) |=> sd_flag);
  a_r9_resume_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(period_end));
  a_r1_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);
  a_r8_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe[0] |-> !pwm_out[0]);
endmodule

bind pwm_bridge_guard pwm_bridge_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .auto_restart(auto_restart),
  .sd_clear(sd_clear), .ssel_ac(ssel_ac), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
  .sd_flag(sd_flag), .period_end(period_end), .run(run)
);

// File: tb/pwm_bridge_guard_bench.sv
`timescale 1ns/1ps
module pwm_bridge_guard_bench;
  logic       clk = 0, rst_n = 0;
  logic [7:0] period_in = 0;
  logic [9:0] duty_in = 0;
  logic       full_bridge = 0, reverse = 0, fault_in = 0, auto_restart = 1, sd_clear = 0;
  logic [1:0] ssel_ac = 0, ssel_bd = 0;
  logic [3:0] pwm_out, pwm_oe;
  logic       sd_flag, period_end;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pwm_bridge_guard u_pwm_bridge_guard (
    .clk(clk), .rst_n(rst_n), .period_in(period_in), .duty_in(duty_in),
    .full_bridge(full_bridge), .reverse(reverse), .fault_in(fault_in),
    .auto_restart(auto_restart), .sd_clear(sd_clear), .ssel_ac(ssel_ac),
    .ssel_bd(ssel_bd), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .sd_flag(sd_flag), .period_end(period_end)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync();
    @(negedge clk);
    while (!period_end) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R0 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int errs, hi, ends, n;
    repeat (3) @(negedge clk);
    check(sd_flag == 0 && period_end == 0, "R11 reset flags", {sd_flag, period_end}, 0);
    check(pwm_out == 4'b0010, "R11 reset pins", pwm_out, 2);
    check(pwm_oe == 4'hF, "R11 reset enables", pwm_oe, 15);
    rst_n = 1;

    // R1 R2 R4 sweep over small periods and all duties around them
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d <= 4*p + 5; d++) begin
        period_in = 8'(p); duty_in = 10'(d);
        sync();
        n = 4*(p+1); errs = 0; hi = 0; ends = 0;
        for (int k = 0; k < n; k++) begin
          int ce;
          @(negedge clk);
          ce = 0;
          if (pwm_out[0] != (k < d)) errs++;
          if (pwm_out[1] == pwm_out[0] || pwm_out[3:2] != 2'b00) ce = 1;
          hi += ce;
          if (period_end != (k == n-1)) ends++;
        end
        check(errs == 0, $sformatf("R2 duty p=%0d d=%0d", p, d), errs, 0);
        check(hi == 0, $sformatf("R4 complement p=%0d d=%0d", p, d), hi, 0);
        check(ends == 0, $sformatf("R1 period end p=%0d", p), ends, 0);
      end
    end

    // R3 mid-period duty write
    period_in = 2; duty_in = 5;
    sync();
    hi = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      hi += pwm_out[0];
      if (k == 1) duty_in = 9;
    end
    check(hi == 5, "R3 held duty", hi, 5);
    hi = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); hi += pwm_out[0]; end
    check(hi == 9, "R3 new duty", hi, 9);

    // R5 R6 full bridge
    duty_in = 5; full_bridge = 1; reverse = 0;
    sync();
    errs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pwm_out != {(k < 5) ? 1'b1 : 1'b0, 2'b00, 1'b1}) errs++;
      if (k == 3) reverse = 1;
    end
    check(errs == 0, "R6 forward kept after mid-period flip", errs, 0);
    errs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pwm_out != {1'b0, 1'b1, (k < 5) ? 1'b1 : 1'b0, 1'b0}) errs++;
    end
    check(errs == 0, "R5 reverse pattern", errs, 0);

    // R7 R8 shutdown states
    full_bridge = 0; reverse = 0; auto_restart = 1;
    ssel_ac = 2'b01; ssel_bd = 2'b10;
    sync(); sync();
    repeat (3) @(negedge clk);
    fault_in = 1; #1;
    check(pwm_out == 4'b0101, "R7 immediate force", pwm_out, 5);
    check(pwm_oe == 4'b0101, "R8 release BD", pwm_oe, 5);
    @(negedge clk);
    check(sd_flag == 1, "R7 flag set", sd_flag, 1);
    ssel_ac = 2'b00; ssel_bd = 2'b01; #1;
    check(pwm_out == 4'b1010 && pwm_oe == 4'hF, "R8 low and high codes", pwm_out, 10);

    // R9 auto restart waits for boundary
    @(negedge clk);
    fault_in = 0;
    @(negedge clk);
    check(sd_flag == 0, "R9 flag clears", sd_flag, 0);
    errs = 0;
    while (!period_end) begin
      if (pwm_out != 4'b1010) errs++;
      @(negedge clk);
    end
    if (pwm_out != 4'b1010) errs++;
    check(errs == 0, "R9 forced until boundary", errs, 0);
    @(negedge clk);
    check(pwm_out == 4'b0001 && pwm_oe == 4'hF, "R9 live at cycle 0", pwm_out, 1);

    // R9 collision: fault released in the last cycle of a period
    fault_in = 1;
    sync();
    fault_in = 0;
    errs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pwm_out != {2'b00, (k < 5) ? 2'b01 : 2'b10}) errs++;
    end
    check(errs == 0, "R9 full pulse after release at boundary", errs, 0);

    // R10 manual restart
    auto_restart = 0;
    fault_in = 1;
    repeat (2) @(negedge clk);
    sd_clear = 1;
    @(negedge clk);
    sd_clear = 0; fault_in = 0;
    check(sd_flag == 1, "R10 clear during fault ignored", sd_flag, 1);
    errs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sd_flag != 1 || pwm_out != 4'b1010) errs++;
    end
    check(errs == 0, "R10 flag and force held", errs, 0);
    sd_clear = 1;
    @(negedge clk);
    sd_clear = 0;
    check(sd_flag == 0, "R10 software clear", sd_flag, 0);
    sync();
    @(negedge clk);
    check(pwm_out == 4'b0001, "R10 live after boundary", pwm_out, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule